// File: doc/BRIEF.md
# Iterative CORDIC Sine and Cosine Engine

This block turns a phase word into its sine and cosine by CORDIC rotation. It uses a single shift-and-add rotation stage, and that stage is reused on every clock cycle. A 16-bit phase covers one full turn. The two top phase bits choose the quadrant. The lower fourteen bits are rotated inside the first quadrant, and the quadrant is then applied to the raw vector to give signed 17-bit results.

A caller places a phase on the input and pulses start while the engine is idle. Busy then stays high for the whole conversion. A one-cycle done pulse marks the moment when cosine, sine and the leftover angle are valid. These outputs hold their values until the next conversion finishes. A new conversion costs 17 cycles plus the cycle in which start is taken, so a stream of angles is handled one after another, not overlapped.

Top module: `cordic_iter_sincos`

## Requirements
- R1: Synchronous active-low reset. After a clock edge with rst_n low: busy_o = 0, done_o = 0, and sin_o, cos_o and eps_o are all 0. This holds even if a conversion was in progress.
- R2: A start_i high sampled at a clock edge while busy_o is low starts a conversion. busy_o is high from that edge until done_o rises, and it is low in every cycle where done_o is high.
- R3: done_o rises exactly 17 clock edges after the edge that accepted start. It stays high for exactly one cycle. There is one done pulse for each accepted start.
- R4: start_i sampled while busy_o is high is ignored. The running conversion finishes on its original schedule with its original result, and no extra done pulse appears.
- R5: Iterations k = 0..15 use 17-bit two's-complement x, y and z, starting from x = 0x09B74, y = 0 and z = phase[13:0] zero-extended. When z is negative (bit 16 set): x += y>>>k, y -= x>>>k, z += A[k]. Otherwise: x -= y>>>k, y += x>>>k, z -= A[k]. Each step uses the x and y values from before that step, and the shifts are arithmetic.
- R6: The angle constants are A = 0x2000, 0x12E4, 0x09FB, 0x0511, 0x028B, 0x0145, 0x00A3, 0x0051, 0x0028, 0x0014, 0x000A, 0x0005, 0x0003, 0x0002, 0x0001, 0x0000 for k = 0..15, in units where 0x10000 is a full turn. eps_o carries the final z.
- R7: With q = phase[15:14] and (x, y) the final vector, the outputs are as follows, where negation is 17-bit two's complement:
  - q=0: cos = x, sin = y
  - q=1: cos = -y, sin = x
  - q=2: cos = -x, sin = -y
  - q=3: cos = y, sin = -x
- R8: sin_o, cos_o and eps_o change only in the cycle where done_o is high, and hold their values otherwise.
- R9: The phase is captured at the accepted start. Later changes on phase_i do not affect the result of the running conversion.
- R10: The results come within 100 LSB of 65535·sin(θ) and 65535·cos(θ), where θ = 2π·phase/65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a conversion; honoured only while idle |
| phase_i | input | 16 | Phase angle, full turn = 2^16 |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| sin_o | output | 17 | Signed sine, scaled by about 65535 |
| cos_o | output | 17 | Signed cosine, scaled by about 65535 |
| eps_o | output | 17 | Signed residual angle after the last iteration |

## Verification
Several properties are checked on every cycle by assertions:
- the controller's timing: the counter advances once per busy cycle, and the finish strobe follows the last iteration;
- the done pulse lasts a single cycle;
- busy is low whenever done is high;
- the outputs hold between done pulses.

Other behaviour can only be shown by the bench's scenarios, which compare results against an independent bit-exact model and a real-valued sine:
- the arithmetic of the iterations;
- the angle constants;
- the four quadrant mappings;
- the rejection of a start during a conversion;
- capture of the phase at start;
- reset in the middle of a conversion.

// File: rtl/cordic_iter_pkg.sv
package cordic_iter_pkg;

   typedef enum logic [1:0] {
      QUAD_I   = 2'd0,
      QUAD_II  = 2'd1,
      QUAD_III = 2'd2,
      QUAD_IV  = 2'd3
   } quad_e;

   // arctan(2^-k) in phase units (full turn = 2^16)
   function automatic logic [15:0] atan_lut(input logic [3:0] k);
      logic [15:0] a;
      case (k)
         4'd0:    a = 16'h2000;
         4'd1:    a = 16'h12E4;
         4'd2:    a = 16'h09FB;
         4'd3:    a = 16'h0511;
         4'd4:    a = 16'h028B;
         4'd5:    a = 16'h0145;
         4'd6:    a = 16'h00A3;
         4'd7:    a = 16'h0051;
         4'd8:    a = 16'h0028;
         4'd9:    a = 16'h0014;
         4'd10:   a = 16'h000A;
         4'd11:   a = 16'h0005;
         4'd12:   a = 16'h0003;
         4'd13:   a = 16'h0002;
         4'd14:   a = 16'h0001;
         default: a = 16'h0000;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/cordic_ashr.sv
// Logarithmic barrel shifter, arithmetic right shift.
module cordic_ashr #(
   parameter int DW = 17,
   parameter int SW = 4
) (
   input  logic signed [DW-1:0] din,
   input  logic        [SW-1:0] amt,
   output logic signed [DW-1:0] dout
);
   logic signed [DW-1:0] lvl [0:SW];

   assign lvl[0] = din;

   for (genvar k = 0; k < SW; k++) begin : g_stage
      assign lvl[k+1] = amt[k] ? (lvl[k] >>> (1 << k)) : lvl[k];
   end

   assign dout = lvl[SW];
endmodule

// File: rtl/cordic_rot_step.sv
// One CORDIC micro-rotation, direction chosen from the sign of z.
module cordic_rot_step
   import cordic_iter_pkg::*;
#(
   parameter int DW = 17,
   parameter int SW = 4
) (
   input  logic signed [DW-1:0] x_in,
   input  logic signed [DW-1:0] y_in,
   input  logic signed [DW-1:0] z_in,
   input  logic        [SW-1:0] idx,
   output logic signed [DW-1:0] x_out,
   output logic signed [DW-1:0] y_out,
   output logic signed [DW-1:0] z_out
);
   localparam int AW = 16;

   logic signed [DW-1:0] x_sh, y_sh, ang;
   logic                 cw;

   cordic_ashr #(.DW(DW), .SW(SW)) u_shx (.din(x_in), .amt(idx), .dout(x_sh));
   cordic_ashr #(.DW(DW), .SW(SW)) u_shy (.din(y_in), .amt(idx), .dout(y_sh));

   assign ang = signed'({{(DW-AW){1'b0}}, atan_lut(4'(idx))});
   assign cw  = z_in[DW-1];

   always_comb begin
      if (cw) begin
         x_out = x_in + y_sh;
         y_out = y_in - x_sh;
         z_out = z_in + ang;
      end else begin
         x_out = x_in - y_sh;
         y_out = y_in + x_sh;
         z_out = z_in - ang;
      end
   end
endmodule

// File: rtl/cordic_iter_ctrl.sv
// Start/iterate/finish sequencer with an iteration counter.
module cordic_iter_ctrl #(
   parameter int ITERS = 16,
   parameter int SW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          load,
   output logic          run,
   output logic          fin,
   output logic [SW-1:0] idx
);
   localparam logic [SW-1:0] LAST = SW'(ITERS - 1);

   assign load = start && !run && !fin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         fin <= 1'b0;
         idx <= '0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            run <= 1'b1;
            idx <= '0;
         end else if (run) begin
            idx <= idx + 1'b1;
            if (idx == LAST) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   // counter steps once per busy cycle regardless of start
   assert_count_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && idx != LAST) |=> (run && idx == $past(idx) + 1'b1));

   // last iteration hands over to the finish cycle
   assert_fin_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && idx == LAST) |=> (fin && !run));

   assert_fin_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);

   assert_load_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (run && idx == '0));
endmodule

// File: rtl/cordic_iter_sincos.sv
module cordic_iter_sincos
   import cordic_iter_pkg::*;
#(
   parameter int          PHASE_W = 16,
   parameter int          DW      = 17,
   parameter int          ITERS   = 16,
   parameter logic [15:0] GAIN    = 16'h9B74
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [PHASE_W-1:0]   phase_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic signed [DW-1:0] sin_o,
   output logic signed [DW-1:0] cos_o,
   output logic signed [DW-1:0] eps_o
);
   localparam int SW = 4;
   localparam int FW = PHASE_W - 2;

   if (PHASE_W != 16) begin : g_bad_phase
      $error("cordic_iter_sincos: angle table assumes a 16-bit phase");
   end
   if (DW < PHASE_W + 1) begin : g_bad_dw
      $error("cordic_iter_sincos: datapath needs a sign bit above the phase");
   end
   if (ITERS < 1 || ITERS > (1 << SW)) begin : g_bad_iters
      $error("cordic_iter_sincos: iteration count out of range");
   end

   logic          load, run, fin;
   logic [SW-1:0] idx;
   quad_e         quad_q;

   logic signed [DW-1:0] x_q, y_q, z_q;
   logic signed [DW-1:0] x_n, y_n, z_n;

   cordic_iter_ctrl #(.ITERS(ITERS), .SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start_i),
      .load(load), .run(run), .fin(fin), .idx(idx)
   );

   cordic_rot_step #(.DW(DW), .SW(SW)) u_step (
      .x_in(x_q), .y_in(y_q), .z_in(z_q), .idx(idx),
      .x_out(x_n), .y_out(y_n), .z_out(z_n)
   );

   // vector registers: folded load, then one micro-rotation per busy cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         quad_q <= QUAD_I;
      end else if (load) begin
         x_q    <= signed'({{(DW-16){1'b0}}, GAIN});
         y_q    <= '0;
         z_q    <= signed'({{(DW-FW){1'b0}}, phase_i[FW-1:0]});
         quad_q <= quad_e'(phase_i[PHASE_W-1 -: 2]);
      end else if (run) begin
         x_q <= x_n;
         y_q <= y_n;
         z_q <= z_n;
      end
   end

   // quadrant unfold into the output registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sin_o  <= '0;
         cos_o  <= '0;
         eps_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= fin;
         if (fin) begin
            eps_o <= z_q;
            case (quad_q)
               QUAD_I:   begin cos_o <= x_q;  sin_o <= y_q;  end
               QUAD_II:  begin cos_o <= -y_q; sin_o <= x_q;  end
               QUAD_III: begin cos_o <= -x_q; sin_o <= -y_q; end
               default:  begin cos_o <= y_q;  sin_o <= -x_q; end
            endcase
         end
      end
   end

   assign busy_o = run | fin;

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(sin_o) && $stable(cos_o) && $stable(eps_o)));

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (!done_o && !busy_o && sin_o == '0 && cos_o == '0));
endmodule

// File: tb/sim_cordic_iter_sincos.sv
`timescale 1ns/1ps
module sim_cordic_iter_sincos;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic [15:0]        phase_i = '0;
   logic               busy_o, done_o;
   logic signed [16:0] sin_o, cos_o, eps_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int dones = 0;
   int pushes = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cordic_iter_sincos u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
      .busy_o(busy_o), .done_o(done_o), .sin_o(sin_o), .cos_o(cos_o), .eps_o(eps_o)
   );

   typedef struct {
      logic [15:0]        ph;
      logic signed [16:0] c, s, e;
      int                 t0;
   } exp_t;

   exp_t sb[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] tb_atan(input int k);
      logic [15:0] t [16] = '{16'h2000, 16'h12E4, 16'h09FB, 16'h0511, 16'h028B, 16'h0145,
                              16'h00A3, 16'h0051, 16'h0028, 16'h0014, 16'h000A, 16'h0005,
                              16'h0003, 16'h0002, 16'h0001, 16'h0000};
      return t[k];
   endfunction

   // bit-exact reference built from R5, R6, R7
   function automatic exp_t model(input logic [15:0] ph);
      exp_t r;
      logic signed [16:0] x, y, z, xn, yn, a;
      x = 17'sh09B74;
      y = '0;
      z = signed'({3'b000, ph[13:0]});
      for (int k = 0; k < 16; k++) begin
         a = signed'({1'b0, tb_atan(k)});
         if (z[16]) begin
            xn = x + (y >>> k);
            yn = y - (x >>> k);
            z  = z + a;
         end else begin
            xn = x - (y >>> k);
            yn = y + (x >>> k);
            z  = z - a;
         end
         x = xn;
         y = yn;
      end
      case (ph[15:14])
         2'd0:    begin r.c = x;  r.s = y;  end
         2'd1:    begin r.c = -y; r.s = x;  end
         2'd2:    begin r.c = -x; r.s = -y; end
         default: begin r.c = y;  r.s = -x; end
      endcase
      r.e  = z;
      r.ph = ph;
      r.t0 = 0;
      return r;
   endfunction

   // driver: one start pulse, expectation pushed to the scoreboard
   task automatic convert(input logic [15:0] ph);
      exp_t e;
      @(negedge clk);
      e = model(ph);
      e.t0 = cyc + 1;
      sb.push_back(e);
      pushes++;
      phase_i = ph;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2", "busy after accepted start", int'(busy_o), 1);
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 40 && (sb.size() != 0 || busy_o); n++) @(negedge clk);
   endtask

   // monitor: pop and compare on every done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         dones++;
         chk(busy_o == 1'b0, "R2", "busy low during done", int'(busy_o), 0);
         if (sb.size() == 0) begin
            chk(1'b0, "R4", "unexpected done pulse", 1, 0);
         end else begin
            exp_t e;
            real th;
            int rs, rc;
            e = sb.pop_front();
            chk(cyc == e.t0 + 17, "R3", "done latency in cycles", cyc - e.t0, 17);
            chk(cos_o == e.c, "R5 R7", $sformatf("cos ph=%h", e.ph), int'(cos_o), int'(e.c));
            chk(sin_o == e.s, "R5 R7", $sformatf("sin ph=%h", e.ph), int'(sin_o), int'(e.s));
            chk(eps_o == e.e, "R6", $sformatf("eps ph=%h", e.ph), int'(eps_o), int'(e.e));
            th = 6.283185307179586 * real'(e.ph) / 65536.0;
            rs = $rtoi(65535.0 * $sin(th));
            rc = $rtoi(65535.0 * $cos(th));
            chk((int'(sin_o) - rs) <= 100 && (rs - int'(sin_o)) <= 100, "R10",
                $sformatf("sin accuracy ph=%h", e.ph), int'(sin_o), rs);
            chk((int'(cos_o) - rc) <= 100 && (rc - int'(cos_o)) <= 100, "R10",
                $sformatf("cos accuracy ph=%h", e.ph), int'(cos_o), rc);
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin : stim
      logic signed [16:0] hs;
      int d0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o == 0 && done_o == 0, "R1", "busy/done at reset", int'({busy_o, done_o}), 0);
      chk(sin_o == 0 && cos_o == 0 && eps_o == 0, "R1", "outputs at reset", int'(sin_o | cos_o), 0);
      rst_n = 1'b1;

      // main function across all quadrants and edges
      foreach (phase_list[i]) begin
         convert(phase_list[i]);
         wait_idle();
      end

      // back-to-back: start again in the cycle done is seen
      convert(16'h3456);
      for (int n = 0; n < 40 && !done_o; n++) @(negedge clk);
      convert(16'hB987);
      wait_idle();

      // R4: second start while busy is ignored
      d0 = dones;
      convert(16'h1234);
      repeat (5) @(negedge clk);
      phase_i = 16'hC000;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_idle();
      repeat (20) @(negedge clk);
      chk(dones == d0 + 1, "R4", "done pulses for one accepted start", dones - d0, 1);

      // R9: phase changes after start do not matter
      convert(16'h2000);
      phase_i = 16'hFFFF;
      repeat (3) @(negedge clk);
      phase_i = 16'h8000;
      wait_idle();

      // R8: outputs hold while idle and while a conversion runs
      hs = sin_o;
      convert(16'h7001);
      repeat (8) @(negedge clk);
      chk(sin_o == hs, "R8", "sin held mid-conversion", int'(sin_o), int'(hs));
      wait_idle();

      // R1: reset in the middle of a conversion
      @(negedge clk);
      phase_i = 16'h5555;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy_o == 0 && done_o == 0, "R1", "busy/done after mid reset", int'({busy_o, done_o}), 0);
      chk(sin_o == 0 && cos_o == 0 && eps_o == 0, "R1", "outputs after mid reset",
          int'(cos_o), 0);
      rst_n = 1'b1;
      repeat (25) @(negedge clk);
      chk(done_o == 0 && busy_o == 0, "R1", "aborted conversion stays silent",
          int'({busy_o, done_o}), 0);

      chk(dones == pushes, "R3", "one done per accepted start", dones, pushes);
      chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
      finish_run();
   end

   logic [15:0] phase_list [12] = '{16'h0000, 16'h2000, 16'h1234, 16'h3FFF,
                                    16'h4000, 16'h6000, 16'h8000, 16'hA123,
                                    16'hC000, 16'hE000, 16'hFFFF, 16'h5A5A};

endmodule